// File: doc/BRIEF.md
# Power-of-Two Window Decomposer

This block turns an address region of arbitrary size into a run of naturally sized address windows, each a power of two bytes, for an address decoder that can only hold power-of-two windows. A command gives a start base, a byte count, a remap (translated) address and a flag saying whether the remap address is in use. In add mode the block peels off the largest power-of-two piece of what remains and sends one add-window request for it over a valid/ready channel. It then moves on until nothing is left. The decoder answers each add with an accept or reject bit sampled on the handshake.

When the decoder rejects an add, the block undoes the partial work. It sends remove requests that cover exactly the chunks already mapped, again from the original base and largest first, and then ends the command with a failure flag. A separate remove mode tears down a region using the same decomposition. A small combinational helper gives the start alignment an allocator must use for a region, so that the first and largest chunk is aligned on its own size.

Top module: `window_decomposer`

## Requirements
- R1: Every request carries a size of exactly one set bit, equal to 2 raised to the index of the highest set bit of the byte count still left; requests therefore come largest first.
- R2: After each accepted add, the next request base is the previous base plus the previous size. When the remaining count reaches zero with no rejection, the command ends with doneOk=1.
- R3: With cmdNoRemap=0 the remap address of each add request is the command remap plus the bytes already mapped. With cmdNoRemap=1 it stays at the command value for every chunk.
- R4: When an add is rejected (reqOk=0 on its handshake), no further add is issued. Remove requests (reqAdd=0) then cover the chunks already accepted, starting at the command base, largest first, and the command ends with doneOk=0.
- R5: A rejection of the very first add produces no remove request and ends the command with doneOk=0.
- R6: With cmdRemove=1 the block issues only remove requests following the R1/R2 decomposition. reqOk is ignored for them and the command ends with doneOk=1.
- R7: A byte count of zero issues no request; doneValid rises one cycle after the command handshake, with doneOk=1.
- R8: doneValid is high for exactly one cycle per command. cmdReady is high only while idle and never while a request is pending. cmdValid presented while busy has no effect on the request stream.
- R9: While reqValid is high and reqReady low, reqValid, reqAdd, reqBase and reqSize hold their values.
- R10: alignOut is the larger of the minimum window (2^16 bytes when alignIsIo=1, 2^20 bytes otherwise) and alignSize rounded down to a power of two. A zero alignSize gives the minimum window.
- R11: After reset cmdReady=1, reqValid=0 and doneValid=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command offered |
| cmdReady | output | 1 | Block idle, command taken on cmdValid |
| cmdRemove | input | 1 | 1 = remove mode, 0 = add mode |
| cmdBase | input | AW | Region start address |
| cmdSize | input | AW | Region byte count |
| cmdRemap | input | AW | Translated address of the region start |
| cmdNoRemap | input | 1 | 1 = remap address unused |
| reqValid | output | 1 | Window request pending |
| reqReady | input | 1 | Decoder takes the request |
| reqAdd | output | 1 | 1 = add window, 0 = remove window |
| reqBase | output | AW | Window base |
| reqSize | output | AW | Window size (power of two) |
| reqRemap | output | AW | Window translated address |
| reqNoRemap | output | 1 | Remap address unused for this window |
| reqOk | input | 1 | Decoder accepted the add (sampled on handshake) |
| doneValid | output | 1 | One-cycle end-of-command pulse |
| doneOk | output | 1 | Command outcome, valid with doneValid |
| alignIsIo | input | 1 | Alignment query is for the I/O space |
| alignSize | input | AW | Alignment query region size |
| alignOut | output | AW | Required start alignment |

## Verification
A command is taken on the rising edge where cmdValid and cmdReady are both high. The first request is visible one cycle later. Each following request appears in the cycle after the previous handshake. doneValid comes one cycle after the last handshake, or one cycle after the command for a zero count. The bench drives and samples on the falling edge and steps one full cycle per handshake, so every request is recorded in the cycle it is offered. It checks the zero-count latency exactly and checks that doneValid has dropped one cycle after it is seen. alignOut is combinational and is sampled one time unit after its inputs change.

// File: rtl/wd_pkg.sv
package wd_pkg;
  typedef struct packed {
    logic load;      // capture a new command
    logic advance;   // consume the current chunk
    logic rollback;  // restart at the base over the mapped bytes
  } wdCtrlT;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } wdStateT;
endpackage

// File: rtl/wd_msb.sv
module wd_msb #(
  parameter int W = 32
) (
  input  logic [W-1:0] vec,
  output logic [W-1:0] hi
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  always_comb begin
    hi = '0;
    for (int i = 0; i < W; i++) begin
      if (vec[i]) hi = ONE << i;
    end
  end
endmodule

// File: rtl/wd_align.sv
module wd_align #(
  parameter int AW           = 32,
  parameter int IO_MIN_LOG2  = 16,
  parameter int MEM_MIN_LOG2 = 20
) (
  input  logic          isIo,
  input  logic [AW-1:0] size,
  output logic [AW-1:0] align
);
  localparam logic [AW-1:0] ONE    = {{(AW-1){1'b0}}, 1'b1};
  localparam logic [AW-1:0] IO_MIN  = ONE << IO_MIN_LOG2;
  localparam logic [AW-1:0] MEM_MIN = ONE << MEM_MIN_LOG2;

  logic [AW-1:0] floorPow;
  logic [AW-1:0] minWin;

  wd_msb #(.W(AW)) floor_i (.vec(size), .hi(floorPow));

  always_comb begin
    minWin = isIo ? IO_MIN : MEM_MIN;
    align  = (floorPow > minWin) ? floorPow : minWin;
  end
endmodule

// File: rtl/wd_datapath.sv
module wd_datapath
  import wd_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  wdCtrlT        ctrl,
  input  logic [AW-1:0] cmdBase,
  input  logic [AW-1:0] cmdSize,
  input  logic [AW-1:0] cmdRemap,
  input  logic          cmdNoRemap,
  output logic [AW-1:0] curBase,
  output logic [AW-1:0] chunk,
  output logic [AW-1:0] curRemap,
  output logic          noRemap,
  output logic          remZero
);
  logic [AW-1:0] startBase;
  logic [AW-1:0] remSize;
  logic [AW-1:0] mappedSize;

  wd_msb #(.W(AW)) chunk_i (.vec(remSize), .hi(chunk));

  assign remZero = (remSize == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startBase  <= '0;
      curBase    <= '0;
      remSize    <= '0;
      mappedSize <= '0;
      curRemap   <= '0;
      noRemap    <= 1'b0;
    end else if (ctrl.load) begin
      startBase  <= cmdBase;
      curBase    <= cmdBase;
      remSize    <= cmdSize;
      mappedSize <= '0;
      curRemap   <= cmdRemap;
      noRemap    <= cmdNoRemap;
    end else if (ctrl.rollback) begin
      curBase    <= startBase;
      remSize    <= mappedSize;
      mappedSize <= '0;
    end else if (ctrl.advance) begin
      curBase    <= curBase + chunk;
      remSize    <= remSize - chunk;
      mappedSize <= mappedSize + chunk;
      if (!noRemap) curRemap <= curRemap + chunk;
    end
  end
endmodule

// File: rtl/wd_control.sv
module wd_control
  import wd_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   cmdValid,
  input  logic   cmdRemove,
  input  logic   remZero,
  input  logic   reqReady,
  input  logic   reqOk,
  output logic   cmdReady,
  output logic   reqValid,
  output logic   reqAdd,
  output logic   doneValid,
  output logic   doneOk,
  output wdCtrlT ctrl
);
  wdStateT state;
  logic    isRemove;
  logic    rolling;
  logic    failed;
  logic    handshake;

  assign cmdReady  = (state == ST_IDLE);
  assign reqValid  = (state == ST_RUN) && !remZero;
  assign reqAdd    = !isRemove && !rolling;
  assign handshake = reqValid && reqReady;

  always_comb begin
    ctrl          = '0;
    ctrl.load     = cmdValid && cmdReady;
    ctrl.rollback = handshake && reqAdd && !reqOk;
    ctrl.advance  = handshake && !ctrl.rollback;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      isRemove  <= 1'b0;
      rolling   <= 1'b0;
      failed    <= 1'b0;
      doneValid <= 1'b0;
      doneOk    <= 1'b0;
    end else begin
      doneValid <= 1'b0;
      if (ctrl.load) begin
        state    <= ST_RUN;
        isRemove <= cmdRemove;
        rolling  <= 1'b0;
        failed   <= 1'b0;
      end else if (state == ST_RUN) begin
        if (ctrl.rollback) begin
          rolling <= 1'b1;
          failed  <= 1'b1;
        end else if (remZero) begin
          state     <= ST_IDLE;
          doneValid <= 1'b1;
          doneOk    <= !failed;
        end
      end
    end
  end
endmodule

// File: rtl/window_decomposer.sv
module window_decomposer
  import wd_pkg::*;
#(
  parameter int AW           = 32,
  parameter int IO_MIN_LOG2  = 16,
  parameter int MEM_MIN_LOG2 = 20
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cmdValid,
  output logic          cmdReady,
  input  logic          cmdRemove,
  input  logic [AW-1:0] cmdBase,
  input  logic [AW-1:0] cmdSize,
  input  logic [AW-1:0] cmdRemap,
  input  logic          cmdNoRemap,
  output logic          reqValid,
  input  logic          reqReady,
  output logic          reqAdd,
  output logic [AW-1:0] reqBase,
  output logic [AW-1:0] reqSize,
  output logic [AW-1:0] reqRemap,
  output logic          reqNoRemap,
  input  logic          reqOk,
  output logic          doneValid,
  output logic          doneOk,
  input  logic          alignIsIo,
  input  logic [AW-1:0] alignSize,
  output logic [AW-1:0] alignOut
);
  wdCtrlT ctrl;
  logic   remZero;

  wd_control ctl_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdRemove(cmdRemove),
    .remZero(remZero), .reqReady(reqReady), .reqOk(reqOk),
    .cmdReady(cmdReady), .reqValid(reqValid), .reqAdd(reqAdd),
    .doneValid(doneValid), .doneOk(doneOk), .ctrl(ctrl)
  );

  wd_datapath #(.AW(AW)) dp_i (
    .clk(clk), .rstN(rstN), .ctrl(ctrl),
    .cmdBase(cmdBase), .cmdSize(cmdSize), .cmdRemap(cmdRemap),
    .cmdNoRemap(cmdNoRemap),
    .curBase(reqBase), .chunk(reqSize), .curRemap(reqRemap),
    .noRemap(reqNoRemap), .remZero(remZero)
  );

  wd_align #(.AW(AW), .IO_MIN_LOG2(IO_MIN_LOG2), .MEM_MIN_LOG2(MEM_MIN_LOG2)) align_i (
    .isIo(alignIsIo), .size(alignSize), .align(alignOut)
  );
endmodule

// File: rtl/wd_checker.sv
module wd_checker #(
  parameter int AW           = 32,
  parameter int IO_MIN_LOG2  = 16,
  parameter int MEM_MIN_LOG2 = 20
) (
  input logic          clk,
  input logic          rstN,
  input logic          cmdReady,
  input logic          reqValid,
  input logic          reqReady,
  input logic          reqAdd,
  input logic          reqOk,
  input logic [AW-1:0] reqBase,
  input logic [AW-1:0] reqSize,
  input logic          doneValid,
  input logic          alignIsIo,
  input logic [AW-1:0] alignSize,
  input logic [AW-1:0] alignOut
);
  localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

  AST_CHUNK_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> ($countones(reqSize) == 1)); // R1

  AST_ADD_BASE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && reqAdd && reqOk) |=>
      (!reqValid || !reqAdd || reqBase == $past(reqBase) + $past(reqSize))); // R2

  AST_NO_ADD_AFTER_REJECT: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && reqAdd && !reqOk) |=> !(reqValid && reqAdd)); // R4

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid); // R8

  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rstN)
    cmdReady |-> !reqValid); // R8

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqReady) |=>
      (reqValid && $stable(reqBase) && $stable(reqSize) && $stable(reqAdd))); // R9

  AST_ALIGN_FLOOR: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(alignOut) == 1) &&
    (alignOut >= (alignIsIo ? (ONE << IO_MIN_LOG2) : (ONE << MEM_MIN_LOG2))) &&
    ((alignOut == (alignIsIo ? (ONE << IO_MIN_LOG2) : (ONE << MEM_MIN_LOG2))) ||
     (alignOut <= alignSize))); // R10
endmodule

bind window_decomposer wd_checker #(
  .AW(AW), .IO_MIN_LOG2(IO_MIN_LOG2), .MEM_MIN_LOG2(MEM_MIN_LOG2)
) chk_i (
  .clk(clk), .rstN(rstN), .cmdReady(cmdReady), .reqValid(reqValid),
  .reqReady(reqReady), .reqAdd(reqAdd), .reqOk(reqOk), .reqBase(reqBase),
  .reqSize(reqSize), .doneValid(doneValid), .alignIsIo(alignIsIo),
  .alignSize(alignSize), .alignOut(alignOut)
);

// File: tb/window_decomposer_tb_top.sv
module window_decomposer_tb_top;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cmdValid = 1'b0;
  logic          cmdReady;
  logic          cmdRemove = 1'b0;
  logic [AW-1:0] cmdBase = '0;
  logic [AW-1:0] cmdSize = '0;
  logic [AW-1:0] cmdRemap = '0;
  logic          cmdNoRemap = 1'b0;
  logic          reqValid;
  logic          reqReady = 1'b0;
  logic          reqAdd;
  logic [AW-1:0] reqBase;
  logic [AW-1:0] reqSize;
  logic [AW-1:0] reqRemap;
  logic          reqNoRemap;
  logic          reqOk = 1'b0;
  logic          doneValid;
  logic          doneOk;
  logic          alignIsIo = 1'b0;
  logic [AW-1:0] alignSize = '0;
  logic [AW-1:0] alignOut;

  int checks = 0;
  int errors = 0;

  // recorded stream
  logic          gotAdd[64];
  logic [AW-1:0] gotBase[64];
  logic [AW-1:0] gotSize[64];
  logic [AW-1:0] gotRemap[64];
  int            gotN;
  logic          gotOk;
  int            gotCycles;
  // expected stream
  logic          expAdd[64];
  logic [AW-1:0] expBase[64];
  logic [AW-1:0] expSize[64];
  logic [AW-1:0] expRemap[64];
  int            expN;
  logic          expOk;

  always #4 clk = ~clk; // 125 MHz

  window_decomposer #(.AW(AW)) dut_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdRemove(cmdRemove), .cmdBase(cmdBase), .cmdSize(cmdSize),
    .cmdRemap(cmdRemap), .cmdNoRemap(cmdNoRemap), .reqValid(reqValid),
    .reqReady(reqReady), .reqAdd(reqAdd), .reqBase(reqBase), .reqSize(reqSize),
    .reqRemap(reqRemap), .reqNoRemap(reqNoRemap), .reqOk(reqOk),
    .doneValid(doneValid), .doneOk(doneOk), .alignIsIo(alignIsIo),
    .alignSize(alignSize), .alignOut(alignOut)
  );

  task automatic check(input bit cond, input string req, input string what,
                       input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] topBit(input logic [AW-1:0] v);
    logic [AW-1:0] r = '0;
    for (int i = 0; i < AW; i++) if (v[i]) r = AW'(1) << i;
    return r;
  endfunction

  task automatic pushExp(input logic add, input logic [AW-1:0] b,
                         input logic [AW-1:0] s, input logic [AW-1:0] r);
    expAdd[expN] = add; expBase[expN] = b; expSize[expN] = s; expRemap[expN] = r;
    expN++;
  endtask

  task automatic buildExp(input logic rem, input logic [AW-1:0] base,
                          input logic [AW-1:0] size, input logic [AW-1:0] remap,
                          input logic noRemap, input int rejectAt);
    logic [AW-1:0] left = size, b = base, r = remap, mapped = '0, c;
    bit fail = 0;
    int k = 0;
    expN = 0;
    while (left != 0) begin
      c = topBit(left);
      pushExp(!rem, b, c, r);
      if (!rem && k == rejectAt) begin fail = 1; break; end
      b += c; left -= c; mapped += c;
      if (!noRemap) r += c;
      k++;
    end
    if (fail) begin
      left = mapped; b = base;
      while (left != 0) begin
        c = topBit(left);
        pushExp(1'b0, b, c, '0);
        b += c; left -= c;
      end
    end
    expOk = !fail;
  endtask

  task automatic runCmd(input logic rem, input logic [AW-1:0] base,
                        input logic [AW-1:0] size, input logic [AW-1:0] remap,
                        input logic noRemap, input int rejectAt,
                        input bit stall, input bit noise);
    int addIdx = 0;
    bit stallPending = stall;
    logic [AW-1:0] holdBase, holdSize;
    logic holdAdd;
    cmdRemove = rem; cmdBase = base; cmdSize = size; cmdRemap = remap;
    cmdNoRemap = noRemap; cmdValid = 1'b1;
    @(posedge clk); @(negedge clk);
    if (noise) begin
      cmdRemove = ~rem; cmdBase = 32'hDEAD_0000; cmdSize = 32'h7; cmdRemap = 32'h1;
    end else cmdValid = 1'b0;
    gotN = 0; gotCycles = 0;
    forever begin
      if (doneValid) begin gotOk = doneOk; break; end
      if (reqValid && stallPending) begin
        reqReady = 1'b0;
        holdBase = reqBase; holdSize = reqSize; holdAdd = reqAdd;
        @(posedge clk); @(negedge clk); gotCycles++;
        check(reqValid && reqBase == holdBase && reqSize == holdSize && reqAdd == holdAdd,
              "R9", "request held while stalled", reqBase, holdBase);
        stallPending = 0;
      end
      if (reqValid) begin
        reqReady = 1'b1;
        reqOk = reqAdd ? (addIdx != rejectAt) : 1'b0;
        if (gotN < 64) begin
          gotAdd[gotN] = reqAdd; gotBase[gotN] = reqBase;
          gotSize[gotN] = reqSize; gotRemap[gotN] = reqRemap;
        end
        gotN++;
        if (reqAdd) addIdx++;
      end else reqReady = 1'b0;
      @(posedge clk); @(negedge clk);
      gotCycles++;
      if (gotCycles > 2000) begin
        check(0, "R2", "command never completed", 0, 1);
        break;
      end
    end
    cmdValid = 1'b0; reqReady = 1'b0; reqOk = 1'b0;
    @(posedge clk); @(negedge clk);
    check(!doneValid, "R8", "done lasts one cycle", AW'(doneValid), 0);
    check(cmdReady, "R8", "ready again when idle", AW'(cmdReady), 1);
  endtask

  task automatic compare(input string req);
    check(gotN == expN, req, "request count", gotN, expN);
    for (int i = 0; i < expN && i < gotN; i++) begin
      check(gotAdd[i] == expAdd[i], req, $sformatf("kind #%0d", i), AW'(gotAdd[i]), AW'(expAdd[i]));
      check(gotBase[i] == expBase[i], req, $sformatf("base #%0d", i), gotBase[i], expBase[i]);
      check(gotSize[i] == expSize[i], req, $sformatf("size #%0d", i), gotSize[i], expSize[i]);
      if (expAdd[i])
        check(gotRemap[i] == expRemap[i], req, $sformatf("remap #%0d", i), gotRemap[i], expRemap[i]);
    end
    check(gotOk == expOk, req, "done outcome", AW'(gotOk), AW'(expOk));
  endtask

  task automatic testReset();
    check(cmdReady, "R11", "cmdReady after reset", AW'(cmdReady), 1);
    check(!reqValid, "R11", "reqValid after reset", AW'(reqValid), 0);
    check(!doneValid, "R11", "doneValid after reset", AW'(doneValid), 0);
  endtask

  task automatic testAddRemap();   // R1 R2 R3
    buildExp(0, 32'h0, 32'h7_0000, 32'h1000_0000, 0, -1);
    runCmd(0, 32'h0, 32'h7_0000, 32'h1000_0000, 0, -1, 0, 0);
    compare("R1/R2/R3 split with remap");
    buildExp(0, 32'h4000_0000, 32'h0123_4000, 32'h0, 0, -1);
    runCmd(0, 32'h4000_0000, 32'h0123_4000, 32'h0, 0, -1, 0, 0);
    compare("R1/R2 many chunks");
  endtask

  task automatic testNoRemap();    // R3
    buildExp(0, 32'h10_0000, 32'h3_0000, 32'h8000_0000, 1, -1);
    runCmd(0, 32'h10_0000, 32'h3_0000, 32'h8000_0000, 1, -1, 0, 0);
    compare("R3 remap unused");
  endtask

  task automatic testReject();     // R4
    buildExp(0, 32'h2000, 32'h1C0, 32'h0, 0, 2);
    runCmd(0, 32'h2000, 32'h1C0, 32'h0, 0, 2, 0, 0);
    compare("R4 rollback");
  endtask

  task automatic testRejectFirst(); // R5
    buildExp(0, 32'h8000, 32'h5000, 32'h0, 0, 0);
    runCmd(0, 32'h8000, 32'h5000, 32'h0, 0, 0, 0, 0);
    compare("R5 first add rejected");
  endtask

  task automatic testRemove();     // R6
    buildExp(1, 32'h3_0000, 32'h5_0000, 32'h0, 0, -1);
    runCmd(1, 32'h3_0000, 32'h5_0000, 32'h0, 0, -1, 0, 0);
    compare("R6 remove mode");
  endtask

  task automatic testZero();       // R7
    buildExp(0, 32'h1234_0000, 32'h0, 32'h0, 0, -1);
    runCmd(0, 32'h1234_0000, 32'h0, 32'h0, 0, -1, 0, 0);
    compare("R7 zero size");
    check(gotCycles == 1, "R7", "done latency", gotCycles, 1);
  endtask

  task automatic testStallNoise(); // R8 R9
    buildExp(0, 32'h0, 32'hB000, 32'h100, 0, -1);
    runCmd(0, 32'h0, 32'hB000, 32'h100, 0, -1, 1, 1);
    compare("R8/R9 stall and busy command");
  endtask

  task automatic alignOne(input logic io, input logic [AW-1:0] sz, input logic [AW-1:0] exp);
    alignIsIo = io; alignSize = sz;
    #1;
    check(alignOut == exp, "R10", $sformatf("align io=%0d size=%0h", io, sz), alignOut, exp);
  endtask

  task automatic testAlign();      // R10
    alignOne(1, 32'h1000, 32'h1_0000);
    alignOne(1, 32'h3_0000, 32'h2_0000);
    alignOne(0, 32'h30_0000, 32'h20_0000);
    alignOne(0, 32'h0, 32'h10_0000);
    alignOne(0, 32'hF_FFFF, 32'h10_0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testAddRemap();
    testNoRemap();
    testReject();
    testRejectFirst();
    testRemove();
    testZero();
    testStallNoise();
    testAlign();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #800000;
    checks++; errors++;
    $display("FAIL R2 watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule